// File: doc/BRIEF.md
# Capture/Compare Timer with Guarded Overflow Flag

This block is a 16-bit up-counter for general timing work. It moves one step for each cycle in which a count-enable strobe is high. Two 16-bit registers sit beside the counter. Compare register 0 sets the period and raises a match pulse. Capture register 1 takes a snapshot of the counter when an external input shows a chosen edge, and then raises a capture pulse. Software reaches both registers through plain write and read strobes.

The counter runs in one of three modes. It can run freely. It can restart from zero once it has reached the compare value. It can restart from zero on each accepted edge of the external input. In every mode, a strobe that finds the counter at FFFFH sets an overflow flag. Software clears that flag with a pulse. A clear that arrives while the counter still sits at 0000H after a rollover is ignored, so an overflow cannot be lost.

A capture can land in the same cycle that software reads capture register 1. In that case the capture still completes, and a read-invalid bit flags the returned data as not to be trusted.

Top module: `cap_timer16`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter, both registers, the overflow flag and both interrupt pulses go to zero.
- R2: The counter adds one only in cycles where `cnt_en` is high. In every other cycle it holds its value, except for the edge clear in R7.
- R3: With `mode` = 2'b01 (match-clear), a counter equal to compare register 0 holds that value until the next strobe. That strobe loads 0000H.
- R4: `match_irq` is high for exactly one cycle: the first cycle in which the counter shows a new value equal to compare register 0.
- R5: `ext_in` passes through two synchronizing flops before edge detection. `edge_sel` chooses the edges: 2'b00 rising, 2'b01 falling, 2'b10 both, 2'b11 none. An edge that is not selected has no effect.
- R6: An accepted edge loads the counter value into capture register 1 on the third rising clock edge after `ext_in` changes. `capture_irq` is high for the single cycle that follows.
- R7: With `mode` = 2'b10 (edge-clear), an accepted edge also loads 0000H into the counter on that same clock edge, whether or not `cnt_en` is high. With `mode` = 2'b00 or 2'b11 (free-running), an edge does not disturb the counter.
- R8: A strobe that finds the counter at FFFFH sets `ovf_flag`. This holds in every mode, including match-clear with compare register 0 at FFFFH.
- R9: After an overflow, `ovf_clr` is ignored until a strobe moves the counter away from 0000H. That includes the strobe cycle itself.
- R10: Outside that window, `ovf_clr` clears the flag on the next edge. An overflow in the same cycle as `ovf_clr` leaves the flag set.
- R11: When a capture falls in the same cycle as a read of capture register 1 (`rd_en` = 1, `rd_sel` = 1), `rd_invalid` is high in that cycle and the capture takes effect. A software write to register 1 in that same cycle is discarded.
- R12: `wr_sel` = 0 writes compare register 0 and `wr_sel` = 1 writes capture register 1. `rd_data` shows the register chosen by `rd_sel` (0 for register 0, 1 for register 1) without a cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count-enable strobe |
| mode | input | 2 | 00 free, 01 match-clear, 10 edge-clear, 11 free |
| edge_sel | input | 2 | 00 rising, 01 falling, 10 both, 11 none |
| ext_in | input | 1 | External edge input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 compare reg 0, 1 capture reg 1 |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read source: 0 compare reg 0, 1 capture reg 1 |
| rd_data | output | 16 | Selected register value |
| rd_invalid | output | 1 | Read collided with a capture |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| ovf_flag | output | 1 | Overflow flag |
| count | output | 16 | Current counter value |
| match_irq | output | 1 | Compare match pulse |
| capture_irq | output | 1 | Capture pulse |

## Verification
The match-pulse property assumes compare register 0 is not rewritten in the cycle it is checked against the counter. For that reason the bench writes register 0 only while the counter is held away from the value being written. The step and hold properties assume `mode` is stable around a strobe, so the stimulus changes mode only on cycles with `cnt_en` low. `ext_in` is treated as asynchronous, and the bench holds each level for at least three clocks so that every edge passes the synchronizer.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_MATCH    = 2'b01,
        MODE_EDGE     = 2'b10,
        MODE_FREE_ALT = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic flag;
        logic win;
    } ovf_state_t;

endpackage

// File: rtl/tmr_edge_unit.sv
module tmr_edge_unit
    import timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       hit
);

    // sh_q[SYNC_STAGES-1] is the synchronized level, sh_q[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] sh_d, sh_q;
    logic                 synced, prev, rise, fall;
    edge_sel_e            sel_e;

    assign sel_e = edge_sel_e'(edge_sel);

    always_comb begin
        sh_d   = {sh_q[SYNC_STAGES-1:0], pin};
        synced = sh_q[SYNC_STAGES-1];
        prev   = sh_q[SYNC_STAGES];
        rise   = synced & ~prev;
        fall   = ~synced & prev;
        case (sel_e)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/tmr_ovf_ctl.sv
module tmr_ovf_ctl
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic next_zero,
    input  logic clr,
    output logic flag,
    output logic window
);

    ovf_state_t ovf_d, ovf_q;

    always_comb begin
        ovf_d = ovf_q;
        // the guard window opens on a rollover and closes once the counter leaves zero
        if (wrap)            ovf_d.win = 1'b1;
        else if (!next_zero) ovf_d.win = 1'b0;
        // a rollover outranks a clear, and a clear inside the window is dropped
        if (wrap)                   ovf_d.flag = 1'b1;
        else if (clr && !ovf_q.win) ovf_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= ovf_d;
    end

    assign flag   = ovf_q.flag;
    assign window = ovf_q.win;

endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
    import timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [1:0]       mode,
    input  logic [1:0]       edge_sel,
    input  logic             ext_in,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_invalid,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] count,
    output logic             match_irq,
    output logic             capture_irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] cc0;
        logic [CNT_W-1:0] cc1;
        logic             match_irq;
        logic             cap_irq;
    } core_t;

    core_t            state_d, state_q;
    cnt_mode_e        mode_e;
    logic             edge_hit;
    logic             clr_edge;
    logic             wrap;
    logic             next_zero;
    logic             ovf_window;
    logic [CNT_W-1:0] cc0_val, cc1_val;

    assign mode_e = cnt_mode_e'(mode);

    tmr_edge_unit #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_in),
        .edge_sel (edge_sel),
        .hit      (edge_hit)
    );

    always_comb begin
        state_d  = state_q;
        clr_edge = edge_hit && (mode_e == MODE_EDGE);

        // counter: edge clear first, then strobe-driven step or match restart
        if (clr_edge) begin
            state_d.count = '0;
        end else if (cnt_en) begin
            if (mode_e == MODE_MATCH && state_q.count == state_q.cc0)
                state_d.count = '0;
            else
                state_d.count = state_q.count + CNT_ONE;
        end

        // compare register: software only
        if (wr_en && !wr_sel)
            state_d.cc0 = wr_data;

        // capture register: a capture beats a same-cycle write
        if (edge_hit)
            state_d.cc1 = state_q.count;
        else if (wr_en && wr_sel)
            state_d.cc1 = wr_data;

        state_d.match_irq = (state_d.count == state_q.cc0) &&
                            (state_d.count != state_q.count);
        state_d.cap_irq   = edge_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wrap      = cnt_en && (state_q.count == CNT_MAX);
    assign next_zero = (state_d.count == '0);

    tmr_ovf_ctl u_ovf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .next_zero (next_zero),
        .clr       (ovf_clr),
        .flag      (ovf_flag),
        .window    (ovf_window)
    );

    assign cc0_val     = state_q.cc0;
    assign cc1_val     = state_q.cc1;
    assign count       = state_q.count;
    assign match_irq   = state_q.match_irq;
    assign capture_irq = state_q.cap_irq;
    assign rd_data     = rd_sel ? state_q.cc1 : state_q.cc0;
    assign rd_invalid  = rd_en && rd_sel && edge_hit;

endmodule

// File: rtl/cap_timer16_chk.sv
module cap_timer16_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [1:0]       mode,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             match_irq,
    input logic             capture_irq,
    input logic             rd_invalid,
    input logic [CNT_W-1:0] cc0,
    input logic [CNT_W-1:0] cc1,
    input logic             win
);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !ovf_flag && !match_irq && !capture_irq &&
                    cc0 == '0 && cc1 == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && mode != 2'b10) |=> $stable(count));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && mode == 2'b00 && count != '1) |=>
            (count == CNT_W'($past(count) + 1'b1)));

    assert_match_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && mode == 2'b01 && count == cc0) |=> (count == '0));

    assert_match_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_irq && $stable(cc0)) |-> (count == cc0));

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture_irq |-> (cc1 == $past(count)));

    assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && count == '1) |=> ovf_flag);

    assert_clear_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win && ovf_clr) |=> ovf_flag);

    assert_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid |=> (capture_irq && cc1 == $past(count)));

endmodule

bind cap_timer16 cap_timer16_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .mode        (mode),
    .ovf_clr     (ovf_clr),
    .count       (count),
    .ovf_flag    (ovf_flag),
    .match_irq   (match_irq),
    .capture_irq (capture_irq),
    .rd_invalid  (rd_invalid),
    .cc0         (cc0_val),
    .cc1         (cc1_val),
    .win         (ovf_window)
);

// File: tb/cap_timer16_test.sv
module cap_timer16_test;

    localparam int SIG_COUNT = 0;
    localparam int SIG_OVF   = 1;
    localparam int SIG_MIRQ  = 2;
    localparam int SIG_CIRQ  = 3;
    localparam int SIG_RD    = 4;
    localparam int SIG_RDINV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  edge_sel = 2'b00;
    logic        ext_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] rd_data;
    logic        rd_invalid;
    logic        ovf_flag;
    logic [15:0] count;
    logic        match_irq;
    logic        capture_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        string       req;
        int          sig;
        logic [15:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    cap_timer16 uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en      (cnt_en),
        .mode        (mode),
        .edge_sel    (edge_sel),
        .ext_in      (ext_in),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .rd_invalid  (rd_invalid),
        .ovf_clr     (ovf_clr),
        .ovf_flag    (ovf_flag),
        .count       (count),
        .match_irq   (match_irq),
        .capture_irq (capture_irq)
    );

    function automatic logic [15:0] observe(input int sig);
        case (sig)
            SIG_COUNT: return count;
            SIG_OVF:   return {15'b0, ovf_flag};
            SIG_MIRQ:  return {15'b0, match_irq};
            SIG_CIRQ:  return {15'b0, capture_irq};
            SIG_RD:    return rd_data;
            default:   return {15'b0, rd_invalid};
        endcase
    endfunction

    function automatic string sig_name(input int sig);
        case (sig)
            SIG_COUNT: return "count";
            SIG_OVF:   return "ovf_flag";
            SIG_MIRQ:  return "match_irq";
            SIG_CIRQ:  return "capture_irq";
            SIG_RD:    return "rd_data";
            default:   return "rd_invalid";
        endcase
    endfunction

    // driver side: queue what the requirements predict for the current cycle
    task automatic expect_sig(input string req, input int sig, input logic [15:0] exp);
        sb_item_t it;
        it.req = req;
        it.sig = sig;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input int n);
        cnt_en = 1'b1;
        tick(n);
        cnt_en = 1'b0;
    endtask

    task automatic write_reg(input logic sel, input logic [15:0] val);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = val;
        tick(1);
        wr_en   = 1'b0;
    endtask

    // monitor side: compare shortly after each falling edge
    initial begin
        forever begin
            sb_item_t it;
            logic [15:0] act;
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                act = observe(it.sig);
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s %s: actual %0h expected %0h",
                             it.req, sig_name(it.sig), act, it.exp);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tick(2);
        expect_sig("R1", SIG_COUNT, 16'h0000);
        expect_sig("R1", SIG_OVF,   16'h0);
        expect_sig("R1", SIG_MIRQ,  16'h0);
        expect_sig("R1", SIG_CIRQ,  16'h0);
        expect_sig("R1", SIG_RD,    16'h0000);
        rst_n = 1'b1;
        tick(1);

        // R2 counting only on strobes
        strobe(5);
        expect_sig("R2", SIG_COUNT, 16'd5);
        tick(3);
        expect_sig("R2", SIG_COUNT, 16'd5);

        // R12 compare register write and readback
        write_reg(1'b0, 16'd7);
        rd_sel = 1'b0;
        expect_sig("R12", SIG_RD, 16'd7);

        // R3 and R4 match-clear mode
        mode = 2'b01;
        strobe(1);
        expect_sig("R4", SIG_COUNT, 16'd6);
        expect_sig("R4", SIG_MIRQ,  16'h0);
        strobe(1);
        expect_sig("R4", SIG_COUNT, 16'd7);
        expect_sig("R4", SIG_MIRQ,  16'h1);
        tick(1);
        expect_sig("R4", SIG_MIRQ,  16'h0);
        expect_sig("R3", SIG_COUNT, 16'd7);
        tick(2);
        expect_sig("R3", SIG_COUNT, 16'd7);
        strobe(1);
        expect_sig("R3", SIG_COUNT, 16'd0);
        expect_sig("R4", SIG_MIRQ,  16'h0);

        // R6 and R7 capture in free-running mode, rising edge
        mode = 2'b00;
        strobe(3);
        ext_in = 1'b1;
        tick(2);
        expect_sig("R6", SIG_CIRQ, 16'h0);
        tick(1);
        rd_sel = 1'b1;
        expect_sig("R6", SIG_RD,    16'd3);
        expect_sig("R6", SIG_CIRQ,  16'h1);
        expect_sig("R7", SIG_COUNT, 16'd3);
        tick(1);
        expect_sig("R6", SIG_CIRQ, 16'h0);

        // R5 falling edge ignored while rising is selected
        strobe(2);
        ext_in = 1'b0;
        tick(3);
        expect_sig("R5", SIG_CIRQ,  16'h0);
        expect_sig("R5", SIG_RD,    16'd3);
        tick(1);
        expect_sig("R5", SIG_CIRQ,  16'h0);

        // R5 and R7 edge-clear mode with falling edge, no strobe needed
        mode     = 2'b10;
        edge_sel = 2'b01;
        ext_in   = 1'b1;
        tick(4);
        expect_sig("R5", SIG_CIRQ,  16'h0);
        expect_sig("R5", SIG_COUNT, 16'd5);
        ext_in = 1'b0;
        tick(3);
        expect_sig("R7", SIG_COUNT, 16'd0);
        expect_sig("R6", SIG_CIRQ,  16'h1);
        expect_sig("R6", SIG_RD,    16'd5);

        // R11 capture collides with a read and a write of register 1
        edge_sel = 2'b10;
        strobe(2);
        ext_in = 1'b1;
        tick(2);
        rd_en   = 1'b1;
        wr_en   = 1'b1;
        wr_sel  = 1'b1;
        wr_data = 16'hABCD;
        expect_sig("R11", SIG_RDINV, 16'h1);
        tick(1);
        rd_en = 1'b0;
        wr_en = 1'b0;
        expect_sig("R11", SIG_RD,    16'd2);
        expect_sig("R11", SIG_RDINV, 16'h0);
        expect_sig("R7",  SIG_COUNT, 16'd0);

        // R12 software write to register 1 without a capture
        write_reg(1'b1, 16'h1234);
        expect_sig("R12", SIG_RD, 16'h1234);

        // R8 and R9 overflow in match-clear mode with compare at FFFFH
        mode = 2'b01;
        write_reg(1'b0, 16'hFFFF);
        rd_sel = 1'b0;
        expect_sig("R12", SIG_RD, 16'hFFFF);
        strobe(65535);
        expect_sig("R8", SIG_COUNT, 16'hFFFF);
        expect_sig("R8", SIG_OVF,   16'h0);
        expect_sig("R4", SIG_MIRQ,  16'h1);
        strobe(1);
        expect_sig("R8", SIG_COUNT, 16'h0000);
        expect_sig("R8", SIG_OVF,   16'h1);
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        expect_sig("R9", SIG_OVF, 16'h1);
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        expect_sig("R9", SIG_OVF, 16'h1);
        strobe(1);
        expect_sig("R9", SIG_COUNT, 16'd1);
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        expect_sig("R10", SIG_OVF, 16'h0);

        // R8 and R10 free-running overflow meeting a clear in the same cycle
        mode = 2'b00;
        strobe(65534);
        expect_sig("R8", SIG_COUNT, 16'hFFFF);
        expect_sig("R8", SIG_OVF,   16'h0);
        cnt_en  = 1'b1;
        ovf_clr = 1'b1;
        tick(1);
        cnt_en  = 1'b0;
        ovf_clr = 1'b0;
        expect_sig("R10", SIG_OVF,   16'h1);
        expect_sig("R10", SIG_COUNT, 16'h0000);
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        expect_sig("R9", SIG_OVF, 16'h1);
        strobe(1);
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        expect_sig("R10", SIG_OVF, 16'h0);

        // R1 reset in mid-run
        strobe(4);
        rst_n = 1'b0;
        tick(1);
        rd_sel = 1'b1;
        expect_sig("R1", SIG_COUNT, 16'h0000);
        expect_sig("R1", SIG_RD,    16'h0000);
        expect_sig("R1", SIG_OVF,   16'h0);
        rst_n = 1'b1;
        tick(2);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule